// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This unit performs one-bit operations on a byte operand, using the carry flag as a one-bit accumulator. Each request supplies an operation code, an operand byte, a bit index and the current carry. One clock later the unit returns three results:

- the edited byte, with a write strobe;
- a new carry, with a write strobe;
- a new zero flag, with a write strobe.

The operations are set, clear, invert and test of one bit. The unit also loads a bit into the carry and stores the carry into a bit. It can AND, OR or XOR the carry with a bit. Load, store and the three logic operations each come in a form that uses the complement of the bit or of the carry.

The bit index normally comes from a 3-bit immediate. For the four byte-editing and test operations, a select line can take the index from the low three bits of a general register instead. A small two-state controller makes the timing. In `ST_IDLE` all outputs are quiet. A request moves the controller to `ST_RESULT`, or keeps it there, and the registered result is presented in that state. The transition `GO_RESULT` is taken on any request. `GO_IDLE` is taken when no request arrives.

Top module: `bitop_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid`, all three write strobes, `res_byte`, `c_out` and `z_out` are 0.
- R2: A request presented on `op_valid` in one cycle produces its result, with `res_valid` high, in the next cycle. A cycle without a request is followed by `res_valid` low, all strobes low, and `res_byte`, `c_out` and `z_out` all 0.
- R3: Codes 0 (set), 1 (clear) and 2 (invert) return the operand with only the selected bit forced to 1, forced to 0 or flipped. They raise `byte_we` and leave `c_we` and `z_we` low.
- R4: For codes 0 to 3 with `idx_from_reg` = 1, the bit index is `bit_reg`. Otherwise it is `bit_imm`. Index i selects operand bit i, where bit 0 is the least significant.
- R5: Codes 4 to 15 ignore `idx_from_reg` and always use `bit_imm`.
- R6: Code 3 (test) drives `z_out` with the complement of the selected bit and raises only `z_we`.
- R7: Code 4 (load) copies the selected bit into `c_out`, and code 5 (inverted load) copies its complement. Both raise only `c_we`.
- R8: Code 6 (store) writes `c_in` into the selected bit, and code 7 (inverted store) writes its complement. Both raise only `byte_we`.
- R9: The logic codes write their result to `c_out` and raise only `c_we`. Codes 8 and 9 compute carry AND bit and carry AND NOT bit. Codes 10 and 11 compute carry OR bit and carry OR NOT bit. Codes 12 and 13 compute carry XOR bit and carry XOR NOT bit.
- R10: Codes 14 and 15 raise no strobe.
- R11: With a valid result, a lowered `byte_we` returns the operand unchanged on `res_byte`, and a lowered `c_we` returns `c_in` on `c_out`. A lowered `z_we` gives `z_out` = 0. `byte_we` and `c_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 4 | Operation code |
| op_byte | input | 8 | Operand byte |
| bit_imm | input | 3 | Immediate bit index |
| bit_reg | input | 3 | Register-sourced bit index |
| idx_from_reg | input | 1 | Take index from bit_reg (codes 0-3 only) |
| c_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result present |
| res_byte | output | 8 | Resulting byte |
| byte_we | output | 1 | Byte write strobe |
| c_out | output | 1 | New carry flag |
| c_we | output | 1 | Carry write strobe |
| z_out | output | 1 | New zero flag |
| z_we | output | 1 | Zero write strobe |

## Verification
Every result is due exactly one clock after its request, because a single register stage sits between the inputs and the outputs. The bench applies each request just after a falling edge. It then samples and compares all seven outputs at the next falling edge against a behavioural model of that request. The model is held in a queue, so back-to-back requests are each checked in their own cycle. After the sweep, one idle cycle confirms that the outputs fall quiet one clock after the requests stop.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
    typedef enum logic [3:0] {
        OP_SET  = 4'd0,
        OP_CLR  = 4'd1,
        OP_INV  = 4'd2,
        OP_TST  = 4'd3,
        OP_LD   = 4'd4,
        OP_ILD  = 4'd5,
        OP_ST   = 4'd6,
        OP_IST  = 4'd7,
        OP_AND  = 4'd8,
        OP_IAND = 4'd9,
        OP_OR   = 4'd10,
        OP_IOR  = 4'd11,
        OP_XOR  = 4'd12,
        OP_IXOR = 4'd13,
        OP_RSV0 = 4'd14,
        OP_RSV1 = 4'd15
    } bop_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bstate_e;
endpackage

// File: rtl/bitop_index.sv
module bitop_index
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  bop_e              opc,
    input  logic              from_reg,
    input  logic [IDX_W-1:0]  imm_idx,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] sel_mask
);
    logic             reg_allowed;
    logic [IDX_W-1:0] eff_idx;

    // Only the byte-editing and test codes may take a register index.
    assign reg_allowed = (opc == OP_SET) || (opc == OP_CLR) ||
                         (opc == OP_INV) || (opc == OP_TST);
    assign eff_idx = (reg_allowed && from_reg) ? reg_idx : imm_idx;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign sel_mask[gi] = (eff_idx == IDX_W'(gi));
    end
endmodule

// File: rtl/bitop_logic.sv
module bitop_logic
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  bop_e              opc,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic              c_cur,
    output logic [DATA_W-1:0] new_byte,
    output logic              new_bwe,
    output logic              new_c,
    output logic              new_cwe,
    output logic              new_z,
    output logic              new_zwe
);
    logic picked;

    assign picked = |(operand & sel_mask);

    always_comb begin
        new_byte = operand;
        new_bwe  = 1'b0;
        new_c    = c_cur;
        new_cwe  = 1'b0;
        new_z    = 1'b0;
        new_zwe  = 1'b0;
        unique case (opc)
            OP_SET:  begin new_byte = operand | sel_mask;  new_bwe = 1'b1; end
            OP_CLR:  begin new_byte = operand & ~sel_mask; new_bwe = 1'b1; end
            OP_INV:  begin new_byte = operand ^ sel_mask;  new_bwe = 1'b1; end
            OP_TST:  begin new_z = ~picked;                new_zwe = 1'b1; end
            OP_LD:   begin new_c = picked;                 new_cwe = 1'b1; end
            OP_ILD:  begin new_c = ~picked;                new_cwe = 1'b1; end
            OP_ST: begin
                new_byte = c_cur ? (operand | sel_mask) : (operand & ~sel_mask);
                new_bwe  = 1'b1;
            end
            OP_IST: begin
                new_byte = c_cur ? (operand & ~sel_mask) : (operand | sel_mask);
                new_bwe  = 1'b1;
            end
            OP_AND:  begin new_c = c_cur & picked;  new_cwe = 1'b1; end
            OP_IAND: begin new_c = c_cur & ~picked; new_cwe = 1'b1; end
            OP_OR:   begin new_c = c_cur | picked;  new_cwe = 1'b1; end
            OP_IOR:  begin new_c = c_cur | ~picked; new_cwe = 1'b1; end
            OP_XOR:  begin new_c = c_cur ^ picked;  new_cwe = 1'b1; end
            OP_IXOR: begin new_c = c_cur ^ ~picked; new_cwe = 1'b1; end
            OP_RSV0, OP_RSV1: begin end
        endcase
    end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
    import bitop_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] op_byte,
    input  logic [IDX_W-1:0]  bit_imm,
    input  logic [IDX_W-1:0]  bit_reg,
    input  logic              idx_from_reg,
    input  logic              c_in,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_byte,
    output logic              byte_we,
    output logic              c_out,
    output logic              c_we,
    output logic              z_out,
    output logic              z_we
);
    bstate_e           state_q, state_d;
    bop_e              opc;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] nbyte, byte_q;
    logic              nbwe, nc, ncwe, nz, nzwe;
    logic              bwe_q, c_q, cwe_q, z_q, zwe_q;

    assign opc = bop_e'(op_code);

    bitop_index #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_idx (
        .opc      (opc),
        .from_reg (idx_from_reg),
        .imm_idx  (bit_imm),
        .reg_idx  (bit_reg),
        .sel_mask (mask)
    );

    bitop_logic #(.DATA_W(DATA_W)) u_logic (
        .opc      (opc),
        .operand  (op_byte),
        .sel_mask (mask),
        .c_cur    (c_in),
        .new_byte (nbyte),
        .new_bwe  (nbwe),
        .new_c    (nc),
        .new_cwe  (ncwe),
        .new_z    (nz),
        .new_zwe  (nzwe)
    );

    // Transitions: GO_RESULT on any request, GO_IDLE otherwise.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = op_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = op_valid ? ST_RESULT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            bwe_q  <= 1'b0;
            c_q    <= 1'b0;
            cwe_q  <= 1'b0;
            z_q    <= 1'b0;
            zwe_q  <= 1'b0;
        end else if (op_valid) begin
            byte_q <= nbyte;
            bwe_q  <= nbwe;
            c_q    <= nc;
            cwe_q  <= ncwe;
            z_q    <= nz;
            zwe_q  <= nzwe;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_byte  = '0;
        byte_we   = 1'b0;
        c_out     = 1'b0;
        c_we      = 1'b0;
        z_out     = 1'b0;
        z_we      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin end
            ST_RESULT: begin
                res_valid = 1'b1;
                res_byte  = byte_q;
                byte_we   = bwe_q;
                c_out     = c_q;
                c_we      = cwe_q;
                z_out     = z_q;
                z_we      = zwe_q;
            end
        endcase
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !(byte_we || c_we || z_we));
    // R11
    byte_c_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_we && c_we));
    // R3
    one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid ##1 byte_we) |-> ($countones(res_byte ^ $past(op_byte)) <= 1));
    // R6
    z_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |-> (!byte_we && !c_we));
    // R11
    c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid ##1 !c_we) |-> (c_out == $past(c_in)));
endmodule

// File: tb/sim_bitop_unit.sv
module sim_bitop_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] op_byte = '0;
    logic [2:0] bit_imm = '0;
    logic [2:0] bit_reg = '0;
    logic       idx_from_reg = 1'b0;
    logic       c_in = 1'b0;
    logic       res_valid, byte_we, c_out, c_we, z_out, z_we;
    logic [7:0] res_byte;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bitop_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_byte(op_byte), .bit_imm(bit_imm), .bit_reg(bit_reg),
        .idx_from_reg(idx_from_reg), .c_in(c_in), .res_valid(res_valid),
        .res_byte(res_byte), .byte_we(byte_we), .c_out(c_out), .c_we(c_we),
        .z_out(z_out), .z_we(z_we)
    );

    // packed expectation: {valid, byte, bwe, c, cwe, z, zwe}
    logic [13:0] exp_q[$];

    function automatic logic [13:0] model(int opc, logic [7:0] b, int imm,
                                          int rg, bit use_reg, bit c);
        int    idx;
        bit    v;
        logic [7:0] ob;
        bit    bwe, oc, cwe, oz, zwe;
        idx = (opc < 4 && use_reg) ? rg : imm;     // R4 R5
        v = b[idx];
        ob = b; oc = c; oz = 0; bwe = 0; cwe = 0; zwe = 0;
        case (opc)
            0: begin ob[idx] = 1'b1; bwe = 1; end  // R3
            1: begin ob[idx] = 1'b0; bwe = 1; end
            2: begin ob[idx] = ~v;   bwe = 1; end
            3: begin oz = ~v; zwe = 1; end        // R6
            4: begin oc = v;  cwe = 1; end        // R7
            5: begin oc = ~v; cwe = 1; end
            6: begin ob[idx] = c;  bwe = 1; end   // R8
            7: begin ob[idx] = ~c; bwe = 1; end
            8: begin oc = c & v;  cwe = 1; end    // R9
            9: begin oc = c & ~v; cwe = 1; end
            10: begin oc = c | v;  cwe = 1; end
            11: begin oc = c | ~v; cwe = 1; end
            12: begin oc = c ^ v;  cwe = 1; end
            13: begin oc = c ^ ~v; cwe = 1; end
            default: ;                            // R10
        endcase
        return {1'b1, ob, bwe, oc, cwe, oz, zwe};
    endfunction

    task automatic compare(string req, logic [13:0] e);
        logic [13:0] a;
        a = {res_valid, res_byte, byte_we, c_out, c_we, z_out, z_we};
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, a, e);
        end
    endtask

    function automatic string req_of(int opc, bit use_reg);
        if (opc < 3)  return use_reg ? "R3/R4" : "R3";
        if (opc == 3) return use_reg ? "R6/R4" : "R6";
        if (opc < 6)  return use_reg ? "R7/R5" : "R7";
        if (opc < 8)  return use_reg ? "R8/R5" : "R8";
        if (opc < 14) return use_reg ? "R9/R5" : "R9/R11";
        return "R10";
    endfunction

    initial begin : stim
        logic [7:0] pats[3] = '{8'hA5, 8'h3C, 8'h00};
        string prev_req;
        repeat (3) @(negedge clk);
        compare("R1", 14'h0);                    // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1", 14'h0);                    // R1 after reset, no request
        prev_req = "";
        for (int p = 0; p < 3; p++)
            for (int opc = 0; opc < 16; opc++)
                for (int ix = 0; ix < 8; ix++)
                    for (int c = 0; c < 2; c++)
                        for (int ur = 0; ur < 2; ur++) begin
                            op_valid = 1'b1;
                            op_code = 4'(opc);
                            op_byte = pats[p];
                            bit_imm = 3'(ix);
                            bit_reg = 3'((ix + 3) % 8);
                            idx_from_reg = ur[0];
                            c_in = c[0];
                            exp_q.push_back(model(opc, pats[p], ix, (ix + 3) % 8,
                                                  ur[0], c[0]));
                            @(negedge clk);
                            compare({"R2 ", req_of(opc, ur[0])}, exp_q.pop_front());
                        end
        op_valid = 1'b0;
        op_byte = 8'hFF;
        @(negedge clk);
        compare("R2", 14'h0);                    // R2 quiet after requests stop
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule